// File: doc/BRIEF.md
# Active Power Gain and Offset Trimmer

This block sits after the multiply-and-filter stage of a single-phase power measurement path. Each cycle in which `in_valid` is high it takes one signed 24-bit active-power sample. It scales the sample by a programmable factor close to one and then adds a fine offset correction. The result is rounded back to 24 bits, clamped at the signed limits and sent out with a valid strobe two clock cycles later.

Two coefficients are set through a single-cycle write port. The first is a 12-bit signed gain trim. The full factor is one plus the code divided by 4096, so a code of 0x7FF gives about +50 % and a code of 0x800 gives -50 %. Each gain step is about 0.0244 %. The second is a 16-bit signed offset trim. It counts in 1/256 of an input LSB, which lets calibration cancel small crosstalk offsets, for example at light load where a full-scale average of 838,861 has dropped a thousandfold. To hold that precision the datapath carries 8 fractional guard bits between the gain product and the final rounding.

Top module: `pwr_trim`

## Requirements
- R1: After a synchronous reset, `out_valid` is 0, `out_data` is 0, and both gain and offset trims are 0, so a sample passes through unchanged.
- R2: With input x (signed 24-bit), gain code g (signed 12-bit) and offset code o (signed 16-bit), the result is clamp(floor((floor(x*(4096+g)/16) + o + 128)/256)). With o = 0 the output is therefore x*(1+g/4096), rounded.
- R3: An offset code of 256 (0x0100) moves the output by exactly one input LSB, and -256 moves it by minus one LSB.
- R4: Fractional results that fall exactly halfway round toward positive infinity (x=5, o=128 gives 6; x=5, o=-128 gives 5).
- R5: A result above 8,388,607 is output as 0x7FFFFF.
- R6: A result below -8,388,608 is output as 0x800000.
- R7: `out_valid` is high exactly two rising edges after each rising edge that samples `in_valid` high, once per sample, and is low otherwise.
- R8: A coefficient write is applied only to samples accepted on a later edge than the write. A sample accepted on the same edge as the write uses the old value, and a sample already in the pipeline keeps the values it was accepted with.
- R9: With `wr_en` high, `wr_sel` = 0 loads `wr_data[11:0]` into the gain trim and ignores `wr_data[15:12]`. `wr_sel` = 1 loads all 16 bits into the offset trim.
- R10: `out_data` holds its last value while `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input sample strobe |
| in_data | input | 24 | Signed active-power sample |
| wr_en | input | 1 | Coefficient write strobe |
| wr_sel | input | 1 | 0 = gain trim, 1 = offset trim |
| wr_data | input | 16 | Coefficient write value |
| out_valid | output | 1 | Result strobe, two cycles after the input |
| out_data | output | 24 | Signed trimmed, rounded and clamped result |

## Verification
The assertions assume that reset is held for at least two edges before the first sample, so the pipeline valid bits start from a known zero. They also assume that `in_valid` and the write strobe are never X outside reset. The bench drives every input from a defined value at a falling edge and holds reset across several edges before any traffic. Samples are sent one at a time, so the strobe-to-result pairing that the latency property expects is never ambiguous.

// File: rtl/pwr_trim_pkg.sv
`timescale 1ns/1ps
package pwr_trim_pkg;

    localparam int SAMPLE_W = 24;
    localparam int GAIN_W   = 12;
    localparam int OFS_W    = 16;
    localparam int GUARD_W  = 8;
    localparam int WDATA_W  = 16;

    localparam int FAC_W   = GAIN_W + 2;
    localparam int PROD_W  = SAMPLE_W + FAC_W;
    localparam int SHIFT_W = GAIN_W - GUARD_W;
    localparam int FIX_W   = PROD_W - SHIFT_W;
    localparam int SUM_W   = FIX_W + 1;
    localparam int RES_W   = SUM_W - GUARD_W;

    typedef enum logic {
        SEL_GAIN = 1'b0,
        SEL_OFS  = 1'b1
    } trim_sel_e;

    typedef struct packed {
        logic signed [GAIN_W-1:0] gain;
        logic signed [OFS_W-1:0]  ofs;
    } trim_coef_t;

    typedef struct packed {
        logic                     vld;
        logic signed [FIX_W-1:0]  fix;
        logic signed [OFS_W-1:0]  ofs;
    } stage1_t;

    function automatic logic signed [SAMPLE_W-1:0] clamp_res(input logic signed [RES_W-1:0] v);
        logic signed [RES_W-1:0] hi;
        logic signed [RES_W-1:0] lo;
        hi = RES_W'($signed({1'b0, {(SAMPLE_W-1){1'b1}}}));
        lo = RES_W'($signed({1'b1, {(SAMPLE_W-1){1'b0}}}));
        if (v > hi)      return hi[SAMPLE_W-1:0];
        else if (v < lo) return lo[SAMPLE_W-1:0];
        else             return v[SAMPLE_W-1:0];
    endfunction

endpackage

// File: rtl/pwr_trim_regs.sv
`timescale 1ns/1ps
module pwr_trim_regs
    import pwr_trim_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic               wr_sel,
    input  logic [WDATA_W-1:0] wr_data,
    output trim_coef_t         coef
);

    trim_sel_e sel;
    assign sel = trim_sel_e'(wr_sel);

    always_ff @(posedge clk) begin
        if (rst) begin
            coef <= '0;
        end else if (wr_en) begin
            case (sel)
                SEL_GAIN: coef.gain <= wr_data[GAIN_W-1:0];
                SEL_OFS:  coef.ofs  <= wr_data[OFS_W-1:0];
                default:  coef      <= coef;
            endcase
        end
    end

    AST_COEF_QUIET: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(coef)); // R9

endmodule

// File: rtl/pwr_trim_gain.sv
`timescale 1ns/1ps
module pwr_trim_gain
    import pwr_trim_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       in_valid,
    input  logic signed [SAMPLE_W-1:0] in_data,
    input  trim_coef_t                 coef,
    output stage1_t                    s1
);

    logic signed [FAC_W-1:0]  fac;
    logic signed [PROD_W-1:0] prod;
    logic signed [PROD_W-1:0] prod_sh;
    logic signed [FIX_W-1:0]  fix;

    // unity plus the signed trim, in units of 2^-GAIN_W
    assign fac     = (FAC_W'(1) <<< GAIN_W) + FAC_W'(coef.gain);
    assign prod    = PROD_W'(in_data) * PROD_W'(fac);
    // keep GUARD_W fractional bits (floor)
    assign prod_sh = prod >>> SHIFT_W;
    assign fix     = prod_sh[FIX_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            s1 <= '0;
        end else begin
            s1.vld <= in_valid;
            if (in_valid) begin
                s1.fix <= fix;
                s1.ofs <= coef.ofs;
            end
        end
    end

    AST_STAGE_FROZEN: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(s1.fix) && $stable(s1.ofs))); // R8

endmodule

// File: rtl/pwr_trim_ofs.sv
`timescale 1ns/1ps
module pwr_trim_ofs
    import pwr_trim_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst,
    input  stage1_t                    s1,
    output logic                       out_valid,
    output logic signed [SAMPLE_W-1:0] out_data
);

    localparam logic signed [SAMPLE_W-1:0] MAX_S = {1'b0, {(SAMPLE_W-1){1'b1}}};
    localparam logic signed [SAMPLE_W-1:0] MIN_S = {1'b1, {(SAMPLE_W-1){1'b0}}};

    logic signed [SUM_W-1:0] sum;
    logic signed [SUM_W-1:0] sum_sh;
    logic signed [RES_W-1:0] res;

    // offset is already in 2^-GUARD_W units; add half an LSB, then floor
    assign sum    = SUM_W'(s1.fix) + SUM_W'(s1.ofs) + (SUM_W'(1) <<< (GUARD_W-1));
    assign sum_sh = sum >>> GUARD_W;
    assign res    = sum_sh[RES_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= s1.vld;
            if (s1.vld) out_data <= clamp_res(res);
        end
    end

    AST_CLAMP_HI: assert property (@(posedge clk) disable iff (rst)
        (s1.vld && (res > RES_W'(MAX_S))) |=> (out_data == MAX_S)); // R5
    AST_CLAMP_LO: assert property (@(posedge clk) disable iff (rst)
        (s1.vld && (res < RES_W'(MIN_S))) |=> (out_data == MIN_S)); // R6
    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !s1.vld |=> $stable(out_data)); // R10

endmodule

// File: rtl/pwr_trim.sv
`timescale 1ns/1ps
module pwr_trim
    import pwr_trim_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    input  logic [SAMPLE_W-1:0] in_data,
    input  logic                wr_en,
    input  logic                wr_sel,
    input  logic [WDATA_W-1:0]  wr_data,
    output logic                out_valid,
    output logic [SAMPLE_W-1:0] out_data
);

    trim_coef_t                 coef;
    stage1_t                    s1;
    logic signed [SAMPLE_W-1:0] res_s;

    pwr_trim_regs i_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .coef    (coef)
    );

    pwr_trim_gain i_gain (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_data  ($signed(in_data)),
        .coef     (coef),
        .s1       (s1)
    );

    pwr_trim_ofs i_ofs (
        .clk       (clk),
        .rst       (rst),
        .s1        (s1),
        .out_valid (out_valid),
        .out_data  (res_s)
    );

    assign out_data = res_s;

    AST_LATENCY_TWO: assert property (@(posedge clk) disable iff (rst)
        in_valid |-> ##2 out_valid); // R7
    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(in_valid, 2)); // R7

endmodule

// File: tb/test_pwr_trim.sv
`timescale 1ns/1ps
module test_pwr_trim;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [23:0] in_data = '0;
    logic        wr_en = 1'b0;
    logic        wr_sel = 1'b0;
    logic [15:0] wr_data = '0;
    logic        out_valid;
    logic [23:0] out_data;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    pwr_trim i_pwr_trim (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .out_valid(out_valid), .out_data(out_data)
    );

    localparam int NV = 14;
    // {sample, gain code, offset code}
    localparam logic [23:0] VX [NV] = '{24'h0CCCCD, 24'd1000, 24'd1000, 24'h0CCCCD,
        24'd5, 24'd5, 24'd5, 24'd0, 24'h7FFFFF, 24'h800000, 24'h7FFFFF,
        24'h800000, 24'hF33333, 24'hFFFFFD};
    localparam logic [11:0] VG [NV] = '{12'h000, 12'h7FF, 12'h800, 12'h001,
        12'h000, 12'h000, 12'h000, 12'h000, 12'h7FF, 12'h7FF, 12'h000,
        12'h800, 12'hFFF, 12'h123};
    localparam logic [15:0] VO [NV] = '{16'h0000, 16'h0000, 16'h0000, 16'h0000,
        16'h0100, 16'h0080, 16'hFF80, 16'hFF00, 16'h0000, 16'h0000, 16'h7FFF,
        16'h8000, 16'h0000, 16'hFF00};
    localparam string VR [NV] = '{"R2", "R2", "R2", "R2", "R3", "R4", "R4", "R3",
        "R5", "R6", "R5", "R2", "R2", "R2"};

    function automatic longint model(longint x, longint g, longint o);
        longint p;
        longint r;
        p = x * (4096 + g);
        r = ((p >>> 4) + o + 128) >>> 8;
        if (r > 8388607) r = 8388607;
        if (r < -8388608) r = -8388608;
        return r;
    endfunction

    task automatic check(input string tag, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic sel, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // drives one sample; returns at the falling edge where the result is valid
    task automatic send(input logic [23:0] x);
        @(negedge clk);
        in_valid = 1'b1; in_data = x;
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
    endtask

    function automatic longint sx(input logic [23:0] v);
        return longint'($signed(v));
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        check("R1 out_valid after reset", longint'(out_valid), 0);
        check("R1 out_data after reset", sx(out_data), 0);
        rst = 1'b0;

        // R1: identity trims after reset
        send(24'd77);
        check("R1 pass-through", sx(out_data), 77);

        // table walk
        for (int i = 0; i < NV; i++) begin
            wr(1'b0, {4'h0, VG[i]});
            wr(1'b1, VO[i]);
            send(VX[i]);
            check({VR[i], " valid"}, longint'(out_valid), 1);
            check({VR[i], " value"}, sx(out_data),
                  model(sx(VX[i]), longint'($signed(VG[i])), longint'($signed(VO[i]))));
        end

        // R7: strobe timing
        wr(1'b0, 16'h0000);
        wr(1'b1, 16'h0000);
        @(negedge clk);
        in_valid = 1'b1; in_data = 24'd300;
        @(negedge clk);
        in_valid = 1'b0;
        check("R7 not valid after one edge", longint'(out_valid), 0);
        @(negedge clk);
        check("R7 valid after two edges", longint'(out_valid), 1);
        check("R7 value", sx(out_data), 300);
        @(negedge clk);
        check("R7 single pulse", longint'(out_valid), 0);
        // R10: held while idle
        check("R10 hold value", sx(out_data), 300);
        repeat (3) @(negedge clk);
        check("R10 hold later", sx(out_data), 300);

        // R8: write on the same edge as a sample
        @(negedge clk);
        in_valid = 1'b1; in_data = 24'd100;
        wr_en = 1'b1; wr_sel = 1'b0; wr_data = 16'h07FF;
        @(negedge clk);
        in_valid = 1'b0; wr_en = 1'b0;
        @(negedge clk);
        check("R8 same-edge write unused", sx(out_data), 100);
        send(24'd100);
        check("R8 next sample uses write", sx(out_data), model(100, 2047, 0));

        // R8: offset write while a sample is in flight
        wr(1'b0, 16'h0000);
        @(negedge clk);
        in_valid = 1'b1; in_data = 24'd40;
        @(negedge clk);
        in_valid = 1'b0;
        wr_en = 1'b1; wr_sel = 1'b1; wr_data = 16'h0100;
        @(negedge clk);
        wr_en = 1'b0;
        check("R8 in-flight sample keeps offset", sx(out_data), 40);
        send(24'd40);
        check("R8 later sample gets offset", sx(out_data), 41);

        // R9: gain ignores upper write bits
        wr(1'b1, 16'h0000);
        wr(1'b0, 16'hF001);
        send(24'h0CCCCD);
        check("R9 gain upper bits ignored", sx(out_data), model(838861, 1, 0));

        // R1: reset clears coefficients
        wr(1'b0, 16'h07FF);
        wr(1'b1, 16'h0400);
        @(negedge clk); rst = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 out_data cleared", sx(out_data), 0);
        rst = 1'b0;
        send(24'hFFFF00);
        check("R1 trims cleared", sx(out_data), -256);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule